// File: doc/BRIEF.md
# SPI Boot-Flash Read Controller with Software Pin Override

This block is the SPI master in front of a boot flash. In normal operation a small hardware engine owns the four SPI pins. For each read request it selects the flash, sends the fast-read opcode, a 24-bit address and one dummy byte, and then collects a 32-bit word most-significant bit first. A clock-divider register sets the SPI clock rate the engine uses.

Software can take over the pins through a mode register. While software owns the pins, a raw pin register drives the data-out line, the clock line and three active-low chip selects. Each rising edge that software writes on the clock bit shifts the data-in pin into a capture register, which software can read back. Software uses this path for any flash sequence the engine does not cover, such as write-enable, status polling, programming and erase.

A request for the pins is granted only once the engine is idle. While software holds the pins, hardware read requests wait. Handing the pins back releases every chip select.

Top module: `sflash_ctrl`

## Requirements
- R1: After reset the mode word reads 0, the divider reads DIV_RST (default 1), the pin register reads 0x0007_0000, the capture register reads 0, and the pins show all chip selects high with the clock low.
- R2: Offset 0 is the mode word. Writing it with bit 0 = 1 requests software ownership. On read, bit 0 returns the request and bit 1 returns the grant. The grant follows the request once the engine is idle.
- R3: Offset 8 is the pin register: bit 0 is data-out, bit 8 is the clock and bits 18:16 are chip selects 2..0. While software owns the pins, the pins show these fields one cycle after the write. While hardware owns them, writes to this register do not reach the pins.
- R4: The chip-select field values 6, 5 and 3 each drive exactly one select low (CS0, CS1 and CS2 respectively). The value 7 deselects every device.
- R5: A write to offset 8 that takes the clock bit from 0 to 1 while software owns the pins shifts the data-in pin into bit 0 of the capture register at offset 12, and older bits move up. All other writes leave the capture register unchanged.
- R6: Writing 0 to the mode word forces the chip-select field to 7 in the same cycle, so every select reads and drives high from then on.
- R7: A hardware read drives CS0 low and sends 0x0B, then the 24 address bits and 8 dummy bits, all MSB first. It then samples 32 data bits MSB first on rising SPI clock edges. It releases CS0 and then returns the word with a one-cycle ready pulse. The engine never lowers any select other than CS0.
- R8: During a hardware transfer, data-out changes only while the SPI clock is low.
- R9: Offset 4 is the divider. Each SPI clock half-period lasts divider+1 system clock cycles.
- R10: While software owns the pins, a hardware read request gets no ready pulse and the pins stay under software control. After the pins are handed back, the pending request is served with correct data.
- R11: A software request written during a hardware transfer reads back as requested but not granted. The transfer completes with correct data, and the grant follows once the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset (0, 4, 8, 12) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| hw_req | input | 1 | Hardware read request, held until ready |
| hw_addr | input | ADDR_W | Flash byte address to read |
| hw_ready | output | 1 | One-cycle pulse: read data valid |
| hw_rdata | output | DATA_W | Word read from the flash |
| spi_clk | output | 1 | SPI clock pin |
| spi_mosi | output | 1 | SPI data-out pin |
| spi_cs_n | output | NCS | Active-low chip selects |
| spi_miso | input | 1 | SPI data-in pin |

## Verification
The contended case is a software ownership request and a hardware transfer landing together. The bench writes the mode word partway through an engine read, checks that the request bit is set while the grant bit stays clear, and checks that the word still arrives intact. A few cycles later it checks that the grant has appeared. In the opposite order, a hardware request is raised while software holds the pins: the bench checks that no ready pulse appears and the pins keep the software pattern, then hands back and compares the served word against a flash model.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
   // Register file geometry
   localparam int REG_W = 32;

   // Word index of each register (byte offset / 4)
   localparam logic [1:0] W_MODE  = 2'd0;
   localparam logic [1:0] W_DIV   = 2'd1;
   localparam logic [1:0] W_PINS  = 2'd2;
   localparam logic [1:0] W_CAP   = 2'd3;

   // Field positions inside the pin register
   localparam int F_DOUT = 0;
   localparam int F_SCLK = 8;
   localparam int F_SEL  = 16;

   // Flash opcodes
   localparam logic [7:0] OP_FAST_READ   = 8'h0B;
   localparam logic [7:0] OP_WR_ENABLE   = 8'h06;
   localparam logic [7:0] OP_RD_STATUS   = 8'h05;
   localparam logic [7:0] OP_PAGE_PROG   = 8'h02;
   localparam logic [7:0] OP_SECT_ERASE  = 8'hD8;

   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_XFER = 2'd1,
      ENG_DONE = 2'd2
   } eng_state_t;
endpackage

// File: rtl/sflash_regs.sv
module sflash_regs
   import sflash_pkg::*;
#(
   parameter int DIV_W   = 4,
   parameter int DIV_RST = 1,
   parameter int NCS     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [3:0]       addr,
   input  logic [REG_W-1:0] wdata,
   input  logic             miso,
   input  logic             eng_idle,
   output logic             sw_req,
   output logic             sw_owner,
   output logic [DIV_W-1:0] div,
   output logic             b_dout,
   output logic             b_sclk,
   output logic [NCS-1:0]   b_sel_n,
   output logic [REG_W-1:0] cap_q
);
   localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RST);

   logic hit;
   logic wr_mode, wr_div, wr_pins;
   logic clk_rise;

   assign hit     = wr && (addr[1:0] == 2'b00);
   assign wr_mode = hit && (addr[3:2] == W_MODE);
   assign wr_div  = hit && (addr[3:2] == W_DIV);
   assign wr_pins = hit && (addr[3:2] == W_PINS);

   // software clock edge: written 1 where the held value is 0
   assign clk_rise = wr_pins && wdata[F_SCLK] && !b_sclk && sw_owner;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_req <= 1'b0;
      end else if (wr_mode) begin
         sw_req <= wdata[0];
      end
   end

   // grant follows request, but only while the engine rests
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_owner <= 1'b0;
      end else if (!sw_req) begin
         sw_owner <= 1'b0;
      end else if (eng_idle) begin
         sw_owner <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div <= DIV_INIT;
      end else if (wr_div) begin
         div <= wdata[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_dout  <= 1'b0;
         b_sclk  <= 1'b0;
         b_sel_n <= '1;
      end else if (wr_mode && !wdata[0]) begin
         b_sel_n <= '1;
      end else if (wr_pins) begin
         b_dout  <= wdata[F_DOUT];
         b_sclk  <= wdata[F_SCLK];
         b_sel_n <= wdata[F_SEL +: NCS];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
      end else if (clk_rise) begin
         cap_q <= {cap_q[REG_W-2:0], miso};
      end
   end
endmodule

// File: rtl/sflash_engine.sv
module sflash_engine
   import sflash_pkg::*;
#(
   parameter int         ADDR_W     = 24,
   parameter int         DATA_W     = 32,
   parameter int         DIV_W      = 4,
   parameter int         DUMMY_BITS = 8,
   parameter int         NCS        = 3,
   parameter int         HW_CS      = 0,
   parameter logic [7:0] CMD        = OP_FAST_READ
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_req,
   input  logic [ADDR_W-1:0] hw_addr,
   input  logic              hold,
   input  logic [DIV_W-1:0]  div,
   input  logic              miso,
   output logic              hw_ready,
   output logic [DATA_W-1:0] hw_rdata,
   output logic              idle,
   output logic              e_sclk,
   output logic              e_dout,
   output logic [NCS-1:0]    e_sel_n
);
   localparam int HDR_BITS = 8 + ADDR_W + DUMMY_BITS;
   localparam int TOT_BITS = HDR_BITS + DATA_W;
   localparam int CNT_W    = $clog2(TOT_BITS);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(TOT_BITS - 1);
   localparam logic [CNT_W-1:0] FIRST_RX = CNT_W'(HDR_BITS);

   eng_state_t           state;
   logic                 phase;
   logic [DIV_W-1:0]     tick;
   logic [CNT_W-1:0]     bit_idx;
   logic [HDR_BITS-1:0]  tx;
   logic [DATA_W-1:0]    rx;
   logic                 half_done;
   logic                 active;

   assign half_done = (tick == div);
   assign active    = (state == ENG_XFER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ENG_IDLE;
         phase   <= 1'b0;
         tick    <= '0;
         bit_idx <= '0;
         tx      <= '0;
         rx      <= '0;
      end else begin
         unique case (state)
            ENG_IDLE: begin
               if (hw_req && !hold) begin
                  state   <= ENG_XFER;
                  tx      <= {CMD, hw_addr, {DUMMY_BITS{1'b0}}};
                  phase   <= 1'b0;
                  tick    <= '0;
                  bit_idx <= '0;
               end
            end
            ENG_XFER: begin
               if (!half_done) begin
                  tick <= tick + 1'b1;
               end else begin
                  tick <= '0;
                  if (!phase) begin
                     phase <= 1'b1;
                     if (bit_idx >= FIRST_RX) begin
                        rx <= {rx[DATA_W-2:0], miso};
                     end
                  end else begin
                     phase <= 1'b0;
                     if (bit_idx == LAST_BIT) begin
                        state <= ENG_DONE;
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                        tx      <= {tx[HDR_BITS-2:0], 1'b0};
                     end
                  end
               end
            end
            ENG_DONE: state <= ENG_IDLE;
            default:  state <= ENG_IDLE;
         endcase
      end
   end

   assign idle     = (state == ENG_IDLE);
   assign hw_ready = (state == ENG_DONE);
   assign hw_rdata = rx;
   assign e_sclk   = active && phase;
   assign e_dout   = active && tx[HDR_BITS-1];

   for (genvar i = 0; i < NCS; i++) begin : g_sel
      if (i == HW_CS) begin : g_boot
         assign e_sel_n[i] = !active;
      end else begin : g_other
         assign e_sel_n[i] = 1'b1;
      end
   end
endmodule

// File: rtl/sflash_pinmux.sv
module sflash_pinmux #(
   parameter int NCS = 3
) (
   input  logic           sw_owner,
   input  logic           b_sclk,
   input  logic           b_dout,
   input  logic [NCS-1:0] b_sel_n,
   input  logic           e_sclk,
   input  logic           e_dout,
   input  logic [NCS-1:0] e_sel_n,
   output logic           spi_clk,
   output logic           spi_mosi,
   output logic [NCS-1:0] spi_cs_n
);
   assign spi_clk  = sw_owner ? b_sclk : e_sclk;
   assign spi_mosi = sw_owner ? b_dout : e_dout;

   for (genvar i = 0; i < NCS; i++) begin : g_cs
      assign spi_cs_n[i] = sw_owner ? b_sel_n[i] : e_sel_n[i];
   end
endmodule

// File: rtl/sflash_ctrl.sv
module sflash_ctrl
   import sflash_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int DATA_W     = 32,
   parameter int DIV_W      = 4,
   parameter int DIV_RST    = 1,
   parameter int DUMMY_BITS = 8,
   parameter int NCS        = 3,
   parameter int HW_CS      = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              hw_req,
   input  logic [ADDR_W-1:0] hw_addr,
   output logic              hw_ready,
   output logic [DATA_W-1:0] hw_rdata,
   output logic              spi_clk,
   output logic              spi_mosi,
   output logic [NCS-1:0]    spi_cs_n,
   input  logic              spi_miso
);
   if (NCS < 1 || NCS > 8) begin : g_bad_ncs
      $error("NCS must lie in 1..8");
   end
   if (HW_CS < 0 || HW_CS >= NCS) begin : g_bad_hwcs
      $error("HW_CS must name an existing select");
   end
   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
      $error("DIV_W must lie in 1..16");
   end
   if (DIV_RST < 0 || DIV_RST >= (1 << DIV_W)) begin : g_bad_divrst
      $error("DIV_RST must fit in DIV_W bits");
   end
   if (DATA_W < 2 || DATA_W > 64 || ADDR_W < 1 || DUMMY_BITS < 1) begin : g_bad_frame
      $error("frame widths out of range");
   end

   logic             sw_req, sw_owner, eng_idle;
   logic [DIV_W-1:0] div;
   logic             b_dout, b_sclk;
   logic [NCS-1:0]   b_sel_n;
   logic [REG_W-1:0] cap_q;
   logic             e_sclk, e_dout;
   logic [NCS-1:0]   e_sel_n;

   sflash_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST), .NCS(NCS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .miso(spi_miso), .eng_idle(eng_idle), .sw_req(sw_req), .sw_owner(sw_owner),
      .div(div), .b_dout(b_dout), .b_sclk(b_sclk), .b_sel_n(b_sel_n), .cap_q(cap_q)
   );

   sflash_engine #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .DUMMY_BITS(DUMMY_BITS),
      .NCS(NCS), .HW_CS(HW_CS), .CMD(OP_FAST_READ)
   ) u_engine (
      .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .hw_addr(hw_addr),
      .hold(sw_req || sw_owner), .div(div), .miso(spi_miso),
      .hw_ready(hw_ready), .hw_rdata(hw_rdata), .idle(eng_idle),
      .e_sclk(e_sclk), .e_dout(e_dout), .e_sel_n(e_sel_n)
   );

   sflash_pinmux #(.NCS(NCS)) u_pinmux (
      .sw_owner(sw_owner), .b_sclk(b_sclk), .b_dout(b_dout), .b_sel_n(b_sel_n),
      .e_sclk(e_sclk), .e_dout(e_dout), .e_sel_n(e_sel_n),
      .spi_clk(spi_clk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
   );

   // register read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr[1:0] == 2'b00) begin
         unique case (reg_addr[3:2])
            W_MODE: begin
               reg_rdata[0] = sw_req;
               reg_rdata[1] = sw_owner;
            end
            W_DIV:  reg_rdata[DIV_W-1:0] = div;
            W_PINS: begin
               reg_rdata[F_DOUT]       = b_dout;
               reg_rdata[F_SCLK]       = b_sclk;
               reg_rdata[F_SEL +: NCS] = b_sel_n;
            end
            W_CAP:  reg_rdata = cap_q;
            default: reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/sflash_ctrl_chk.sv
module sflash_ctrl_chk #(
   parameter int NCS = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           reg_wr,
   input logic           sw_req,
   input logic           sw_owner,
   input logic           hw_ready,
   input logic           spi_clk,
   input logic           spi_mosi,
   input logic [NCS-1:0] spi_cs_n,
   input logic [31:0]    cap_q
);
   // R10
   stall_while_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_owner |-> !hw_ready);

   // R6
   handback_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sw_req) && sw_owner) |-> (spi_cs_n == '1));

   // R7
   ready_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_ready |=> !hw_ready);

   // R7
   engine_one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_owner |-> ($countones(~spi_cs_n) <= 1));

   // R8
   mode0_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_owner && spi_clk) |-> $stable(spi_mosi));

   // R5
   capture_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_q) |-> ($past(reg_wr) && $past(sw_owner)));
endmodule

bind sflash_ctrl sflash_ctrl_chk #(.NCS(NCS)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .sw_req(sw_req), .sw_owner(sw_owner),
   .hw_ready(hw_ready), .spi_clk(spi_clk), .spi_mosi(spi_mosi),
   .spi_cs_n(spi_cs_n), .cap_q(cap_q)
);

// File: tb/test_sflash_ctrl.sv
module test_sflash_ctrl;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr;
   logic [3:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic        hw_req;
   logic [23:0] hw_addr;
   logic        hw_ready;
   logic [31:0] hw_rdata;
   logic        spi_clk, spi_mosi;
   logic [2:0]  spi_cs_n;
   logic        spi_miso;
   logic        mdl_en, mdl_miso, sw_miso;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   assign spi_miso = mdl_en ? mdl_miso : sw_miso;

   sflash_ctrl i_sflash_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
      .hw_addr(hw_addr), .hw_ready(hw_ready), .hw_rdata(hw_rdata),
      .spi_clk(spi_clk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
      .spi_miso(spi_miso)
   );

   function automatic logic [31:0] flash_word(input logic [23:0] a);
      return {a, 8'h5A} ^ 32'hC3A5_0F1E;
   endfunction

   // flash model on CS0, mode 0
   int          mcnt = 0;
   logic [39:0] mrx  = '0;
   always @(posedge spi_clk or posedge spi_cs_n[0]) begin
      if (spi_cs_n[0]) mcnt = 0;
      else if (mdl_en) begin
         if (mcnt < 40) mrx = {mrx[38:0], spi_mosi};
         mcnt++;
      end
   end
   always @(negedge spi_clk) begin
      logic [31:0] w;
      if (mdl_en && !spi_cs_n[0] && mcnt >= 40 && mcnt < 72) begin
         w = flash_word(mrx[31:8]);
         mdl_miso = w[71 - mcnt];
      end
   end

   // SPI clock high-time measurement
   int hi_run = 0, last_hi = 0;
   always @(negedge clk) begin
      if (spi_clk) hi_run++;
      else if (hi_run != 0) begin
         last_hi = hi_run;
         hi_run  = 0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic hw_read(input logic [23:0] a, output logic [31:0] d, output bit got);
      @(negedge clk);
      hw_req = 1'b1; hw_addr = a; got = 1'b0; d = '0;
      for (int i = 0; i < 6000 && !got; i++) begin
         @(negedge clk);
         if (hw_ready) begin
            got = 1'b1;
            d   = hw_rdata;
         end
      end
      hw_req = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] r, d, exp_sh, v;
      logic [23:0] a;
      logic [2:0]  pat;
      logic [3:0]  dv;
      bit          got, prev_ck, ck, dout;
      void'($urandom(32'd20240611));
      rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      hw_req = 1'b0; hw_addr = '0; mdl_en = 1'b1; mdl_miso = 1'b0; sw_miso = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'h0, r); chk("R1 mode", r, 32'h0);
      rd(4'h4, r); chk("R1 div", r, 32'h1);
      rd(4'h8, r); chk("R1 pins reg", r, 32'h0007_0000);
      rd(4'hC, r); chk("R1 capture", r, 32'h0);
      chk("R1 cs pins", {29'b0, spi_cs_n}, 32'h7);
      chk("R1 clk pin", {31'b0, spi_clk}, 32'h0);

      // R7 / R9 hardware reads, random and edge addresses
      for (int i = 0; i < 8; i++) begin
         dv = (i == 7) ? 4'd15 : 4'($urandom % 4);
         a  = (i == 0) ? 24'h000000 : (i == 1) ? 24'hFFFFFF : 24'($urandom);
         wr(4'h4, {28'b0, dv});
         hw_read(a, d, got);
         chk("R7 ready seen", {31'b0, got}, 32'h1);
         chk("R7 data", d, flash_word(a));
         chk("R7 opcode", {24'b0, mrx[39:32]}, 32'h0B);
         chk("R7 address", {8'b0, mrx[31:8]}, {8'b0, a});
         chk("R7 cs released", {29'b0, spi_cs_n}, 32'h7);
         chk("R9 half period", last_hi, dv + 1);
      end

      // R2 software ownership
      wr(4'h0, 32'h1);
      rd(4'h0, r); chk("R2 request and grant", r, 32'h3);

      // R3 R4 R5 random bit-bang
      mdl_en = 1'b0;
      prev_ck = 1'b0; exp_sh = '0;
      for (int i = 0; i < 48; i++) begin
         case ($urandom % 4)
            0: pat = 3'd6;
            1: pat = 3'd5;
            2: pat = 3'd3;
            default: pat = 3'd7;
         endcase
         ck = 1'($urandom); dout = 1'($urandom);
         sw_miso = 1'($urandom);
         v = {13'b0, pat, 7'b0, ck, 7'b0, dout};
         wr(4'h8, v);
         if (ck && !prev_ck) exp_sh = {exp_sh[30:0], sw_miso};
         prev_ck = ck;
         chk("R3 mosi pin", {31'b0, spi_mosi}, {31'b0, dout});
         chk("R3 clk pin", {31'b0, spi_clk}, {31'b0, ck});
         chk("R4 select pins", {29'b0, spi_cs_n}, {29'b0, pat});
         rd(4'h8, r); chk("R3 pins readback", r, v);
         rd(4'hC, r); chk("R5 capture", r, exp_sh);
      end

      // R5 directed: rise captures, held high does not
      wr(4'h8, 32'h0006_0000);
      sw_miso = 1'b1;
      wr(4'h8, 32'h0006_0100);
      exp_sh = {exp_sh[30:0], 1'b1};
      rd(4'hC, r); chk("R5 rising capture", r, exp_sh);
      sw_miso = 1'b0;
      wr(4'h8, 32'h0006_0100);
      rd(4'hC, r); chk("R5 held high no capture", r, exp_sh);

      // R4 directed patterns
      for (int k = 0; k < 4; k++) begin
         pat = (k == 0) ? 3'd6 : (k == 1) ? 3'd5 : (k == 2) ? 3'd3 : 3'd7;
         wr(4'h8, {13'b0, pat, 16'b0});
         chk("R4 pattern", {29'b0, spi_cs_n}, {29'b0, pat});
      end

      // R10 stall while software owns the pins
      wr(4'h8, 32'h0005_0000);
      @(negedge clk);
      hw_req = 1'b1; hw_addr = 24'h123456;
      got = 1'b0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (hw_ready) got = 1'b1;
      end
      chk("R10 no ready while owned", {31'b0, got}, 32'h0);
      chk("R10 pins stay software", {29'b0, spi_cs_n}, 32'h5);
      mdl_en = 1'b1;
      wr(4'h0, 32'h0);
      chk("R6 selects released", {29'b0, spi_cs_n}, 32'h7);
      rd(4'h8, r); chk("R6 select field forced", {29'b0, r[18:16]}, 32'h7);
      got = 1'b0;
      for (int i = 0; i < 6000 && !got; i++) begin
         @(negedge clk);
         if (hw_ready) begin got = 1'b1; d = hw_rdata; end
      end
      hw_req = 1'b0;
      chk("R10 served after handback", {31'b0, got}, 32'h1);
      chk("R10 data", d, flash_word(24'h123456));

      // R3 R5 writes ignored while hardware owns the pins
      rd(4'hC, exp_sh);
      mdl_en = 1'b0;
      wr(4'h8, 32'h0000_0000);
      sw_miso = 1'b1;
      wr(4'h8, 32'h0000_0101);
      rd(4'hC, r); chk("R5 no capture without grant", r, exp_sh);
      chk("R3 clk pin unaffected", {31'b0, spi_clk}, 32'h0);
      chk("R3 cs pins unaffected", {29'b0, spi_cs_n}, 32'h7);
      wr(4'h8, 32'h0007_0000);
      mdl_en = 1'b1;

      // R11 request during a transfer
      wr(4'h4, 32'h2);
      a = 24'hA5C3E1;
      fork
         hw_read(a, d, got);
         begin
            repeat (30) @(negedge clk);
            wr(4'h0, 32'h1);
            rd(4'h0, r); chk("R11 pending grant", r, 32'h1);
         end
      join
      chk("R11 ready seen", {31'b0, got}, 32'h1);
      chk("R11 data intact", d, flash_word(a));
      repeat (3) @(negedge clk);
      rd(4'h0, r); chk("R11 grant after idle", r, 32'h3);
      wr(4'h0, 32'h0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule